// File: doc/BRIEF.md
# Multi-Successor Block Branch Predictor

This block predicts the next atomic block for a front end that fetches one block per cycle. A block can have up to eight successors. One trap branch and up to two fault branches choose among them. A small target buffer, indexed by block address, keeps eight successor target slots for each block. It also keeps a count field (log2 of the number of successors) that comes from the block's trap operation. A pattern table holds three 2-bit saturating counters per entry: one for the trap and one for each fault. Its index is a global history register XORed with low block-address bits. The three counters together form a 3-bit successor selector, and that selector picks the target slot.

Each successful prediction shifts only as many history bits as the block needs to name its successor, which is 1 to 3 bits. A resolution port reports the real outcome of a block. It trains the counters, allocates or fills target slots, and repairs the history after a wrong or missing prediction. After reset, the pattern table spends a fixed sweep of cycles writing its initial counter values. During that sweep the block makes no predictions.

Top module: `msbp_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `pred_strobe` and `pred_valid` are 0 and `pred_hist` is 0. All target-buffer entries start invalid.
- R2: A lookup that finds no valid entry with a matching tag, or whose selected slot is empty, gives `pred_valid`=0, `pred_sel`=0 and `pred_tgt` = `lk_addr`+1. It leaves the history register unchanged.
- R3: When a resolution names a block that has no entry, the entry is allocated and the count field is stored. Slot 0 gets `rs_tgt_false`, slot 1 gets `rs_tgt_true`, and if the actual selector is 2 or more, that slot gets `rs_tgt`. Every other slot is empty.
- R4: The selector is {fault2, fault1, trap}, where each bit is the MSB of its counter. The fault1 bit is forced to 0 when the count field is below 2. The fault2 bit is forced to 0 when the count field is below 3. The selector value is the slot number.
- R5: Every counter starts at 01 (weakly not taken), so a freshly trained-free block predicts selector 0.
- R6: Each resolution moves the counters one step toward the actual selector bits and saturates at 00 and 11. Only the counters within the count field are moved.
- R7: On a hit, the history becomes (history << n) | (selector & (2^n - 1)), where n is the stored count field and a count of 0 acts as 1. `pred_hist` reports the history the lookup used.
- R8: The pattern-table index is history XOR the low block-address bits. Lookups use the live history. Resolutions use `rs_hist`.
- R9: A resolution is a misprediction when `rs_was_pred` is 0 or `rs_pred_sel` differs from the masked actual selector. On a misprediction the history becomes (`rs_hist` << n) | actual bits, and this overrides any shift from a lookup in the same cycle. A correct resolution leaves the history alone.
- R10: A misprediction that resolves to an existing entry writes `rs_tgt` into the slot the actual selector names and marks that slot filled.
- R11: A lookup and a resolution in the same cycle both take effect. The lookup sees the table contents as they were before that resolution.
- R12: The prediction outputs are registered. They appear one cycle after `lk_valid`, marked by `pred_strobe`.
- R13: For 2^HW cycles after reset, the pattern table is being initialised. During that time lookups report `pred_valid`=0 and resolutions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | AW | Address of the block being fetched |
| rs_valid | input | 1 | Resolution report this cycle |
| rs_addr | input | AW | Address of the resolved block |
| rs_hist | input | HW | History snapshot taken at prediction time |
| rs_was_pred | input | 1 | The block was fetched with a valid prediction |
| rs_pred_sel | input | 3 | Selector that was predicted |
| rs_sel | input | 3 | Actual selector {fault2, fault1, trap} |
| rs_nlog | input | 2 | log2 of the successor count, taken from the trap operation |
| rs_tgt | input | AW | Actual successor address |
| rs_tgt_true | input | AW | Trap target when the trap condition is true |
| rs_tgt_false | input | AW | Trap target when the trap condition is false |
| pred_strobe | output | 1 | Prediction outputs belong to last cycle's lookup |
| pred_valid | output | 1 | Predicted target is valid |
| pred_sel | output | 3 | Predicted selector |
| pred_tgt | output | AW | Predicted next block, or fall-through address |
| pred_hist | output | HW | History used by the lookup |

## Verification
The bench builds the block with AW=12, HW=6 and BI=3. This gives a 64-entry pattern table and an 8-entry target buffer. With these sizes the initialisation sweep finishes in 64 cycles. Random traffic over ten addresses causes target-buffer evictions, aliasing between blocks in the pattern table, and history wrap-around within a few hundred cycles. Count fields of 0 to 3 are drawn for every address, so the masking of fault bits and the 1-bit, 2-bit and 3-bit history shifts all occur often, alongside same-cycle lookup and repair.

// File: rtl/msbp_pkg.sv
package msbp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;

  typedef struct packed {
    ctr2_t f2;
    ctr2_t f1;
    ctr2_t trap;
  } ctr_set_t;

  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t r;
    if (up) r = (c == 2'b11) ? c : c + 2'd1;
    else    r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic [1:0] clamp_n(logic [1:0] n);
    return (n == 2'd0) ? 2'd1 : n;
  endfunction

  function automatic logic [2:0] mask_sel(logic [2:0] s, logic [1:0] n);
    logic [2:0] m;
    m = s;
    if (n < 2'd3) m[2] = 1'b0;
    if (n < 2'd2) m[1] = 1'b0;
    return m;
  endfunction

endpackage

// File: rtl/msbp_pht.sv
module msbp_pht
  import msbp_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] rd_idx,
  output ctr_set_t      rd_ctr,
  input  logic          up_en,
  input  logic [HW-1:0] up_idx,
  input  logic [2:0]    up_sel,
  input  logic [1:0]    up_n,
  output logic          init_busy
);
  localparam int DEPTH = 1 << HW;

  ctr_set_t      mem [DEPTH];
  logic [HW-1:0] init_idx;
  ctr_set_t      old_c, new_c;

  assign rd_ctr = mem[rd_idx];
  assign old_c  = mem[up_idx];

  always_comb begin
    new_c      = old_c;
    new_c.trap = ctr_step(old_c.trap, up_sel[0]);
    if (up_n >= 2'd2) new_c.f1 = ctr_step(old_c.f1, up_sel[1]);
    if (up_n == 2'd3) new_c.f2 = ctr_step(old_c.f2, up_sel[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
    end else if (init_busy) begin
      init_idx <= init_idx + 1'b1;
      if (init_idx == {HW{1'b1}}) init_busy <= 1'b0;
    end
  end

  // single write port: sweep first, then training updates
  always_ff @(posedge clk) begin
    if (init_busy)  mem[init_idx] <= '{f2: CTR_WEAK_NT, f1: CTR_WEAK_NT, trap: CTR_WEAK_NT};
    else if (up_en) mem[up_idx]   <= new_c;
  end

  a_r13_init_len: assert property (@(posedge clk) disable iff (rst)
    $fell(init_busy) |-> $past(init_idx) == {HW{1'b1}});

endmodule

// File: rtl/msbp_btb.sv
module msbp_btb #(
  parameter int AW = 16,
  parameter int BI = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_hit,
  output logic [1:0]          rd_n,
  output logic [7:0]          rd_slot_v,
  output logic [7:0][AW-1:0]  rd_tgts,
  input  logic                wr_en,
  input  logic                wr_fill,
  input  logic [AW-1:0]       wr_addr,
  input  logic [2:0]          wr_sel,
  input  logic [1:0]          wr_n,
  input  logic [AW-1:0]       wr_tgt,
  input  logic [AW-1:0]       wr_tgt_true,
  input  logic [AW-1:0]       wr_tgt_false
);
  localparam int ENT   = 1 << BI;
  localparam int TW    = AW - BI;
  localparam int SLOTS = 8;

  logic          ent_v   [ENT];
  logic [TW-1:0] ent_tag [ENT];
  logic [1:0]    ent_n   [ENT];
  logic [7:0]    slot_v  [ENT];
  logic [AW-1:0] slot_tgt [ENT][SLOTS];

  logic [BI-1:0] ridx, widx;
  logic          wr_hit;

  assign ridx   = rd_addr[BI-1:0];
  assign widx   = wr_addr[BI-1:0];
  assign rd_hit = ent_v[ridx] && (ent_tag[ridx] == rd_addr[AW-1:BI]);
  assign rd_n   = ent_n[ridx];
  assign rd_slot_v = slot_v[ridx];
  assign wr_hit = ent_v[widx] && (ent_tag[widx] == wr_addr[AW-1:BI]);

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign rd_tgts[s] = slot_tgt[ridx][s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENT; e++) begin
        ent_v[e]   <= 1'b0;
        ent_tag[e] <= '0;
        ent_n[e]   <= 2'd1;
        slot_v[e]  <= '0;
      end
    end else if (wr_en) begin
      if (!wr_hit) begin
        ent_v[widx]   <= 1'b1;
        ent_tag[widx] <= wr_addr[AW-1:BI];
        ent_n[widx]   <= wr_n;
        slot_v[widx]  <= 8'b0000_0011 | (8'b1 << wr_sel);
      end else if (wr_fill) begin
        slot_v[widx][wr_sel] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en) begin
      if (!wr_hit) begin
        slot_tgt[widx][0] <= wr_tgt_false;
        slot_tgt[widx][1] <= wr_tgt_true;
        if (wr_sel > 3'd1) slot_tgt[widx][wr_sel] <= wr_tgt;
      end else if (wr_fill) begin
        slot_tgt[widx][wr_sel] <= wr_tgt;
      end
    end
  end

  a_r3_alloc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit) |=> ent_v[$past(widx)] && slot_v[$past(widx)][0] && slot_v[$past(widx)][1]);

endmodule

// File: rtl/msbp_hist.sv
module msbp_hist #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic [1:0]    shift_n,
  input  logic [2:0]    shift_bits,
  input  logic          fix_en,
  input  logic [HW-1:0] fix_snap,
  input  logic [1:0]    fix_n,
  input  logic [2:0]    fix_bits,
  output logic [HW-1:0] ghr
);

  function automatic logic [HW-1:0] push(logic [HW-1:0] h, logic [1:0] n, logic [2:0] b);
    logic [HW-1:0] r;
    case (n)
      2'd1:    r = {h[HW-2:0], b[0]};
      2'd2:    r = {h[HW-3:0], b[1:0]};
      default: r = {h[HW-4:0], b[2:0]};
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)           ghr <= '0;
    else if (fix_en)   ghr <= push(fix_snap, fix_n, fix_bits);
    else if (shift_en) ghr <= push(ghr, shift_n, shift_bits);
  end

  a_r9_repair: assert property (@(posedge clk) disable iff (rst)
    fix_en |=> ghr[0] == $past(fix_bits[0]));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !fix_en) |=> $stable(ghr));

endmodule

// File: rtl/msbp_top.sv
module msbp_top
  import msbp_pkg::*;
#(
  parameter int AW = 16,
  parameter int HW = 12,
  parameter int BI = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          rs_valid,
  input  logic [AW-1:0] rs_addr,
  input  logic [HW-1:0] rs_hist,
  input  logic          rs_was_pred,
  input  logic [2:0]    rs_pred_sel,
  input  logic [2:0]    rs_sel,
  input  logic [1:0]    rs_nlog,
  input  logic [AW-1:0] rs_tgt,
  input  logic [AW-1:0] rs_tgt_true,
  input  logic [AW-1:0] rs_tgt_false,
  output logic          pred_strobe,
  output logic          pred_valid,
  output logic [2:0]    pred_sel,
  output logic [AW-1:0] pred_tgt,
  output logic [HW-1:0] pred_hist
);
  localparam int LW = (AW < HW) ? AW : HW;

  logic                busy;
  logic [HW-1:0]       ghr, lk_idx, rs_idx;
  ctr_set_t            lk_ctr;
  logic                btb_hit;
  logic [1:0]          btb_n;
  logic [7:0]          btb_sv;
  logic [7:0][AW-1:0]  btb_tgts;

  logic [1:0]    n_l, n_r, pred_n;
  logic [2:0]    sel_l, sel_r;
  logic          hit_l, rs_ok, miss_r;

  assign lk_idx = ghr ^ HW'(lk_addr[LW-1:0]);
  assign rs_idx = rs_hist ^ HW'(rs_addr[LW-1:0]);

  // lookup path
  assign n_l   = clamp_n(btb_n);
  assign sel_l = mask_sel({lk_ctr.f2[1], lk_ctr.f1[1], lk_ctr.trap[1]}, n_l);
  assign hit_l = !busy && btb_hit && btb_sv[sel_l];

  // resolution path
  assign rs_ok  = rs_valid && !busy;
  assign n_r    = clamp_n(rs_nlog);
  assign sel_r  = mask_sel(rs_sel, n_r);
  assign miss_r = !rs_was_pred || (rs_pred_sel != sel_r);

  msbp_pht #(.HW(HW)) u_pht (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_ctr(lk_ctr),
    .up_en(rs_ok), .up_idx(rs_idx), .up_sel(sel_r), .up_n(n_r),
    .init_busy(busy)
  );

  msbp_btb #(.AW(AW), .BI(BI)) u_btb (
    .clk(clk), .rst(rst),
    .rd_addr(lk_addr), .rd_hit(btb_hit), .rd_n(btb_n), .rd_slot_v(btb_sv), .rd_tgts(btb_tgts),
    .wr_en(rs_ok), .wr_fill(miss_r), .wr_addr(rs_addr), .wr_sel(sel_r), .wr_n(n_r),
    .wr_tgt(rs_tgt), .wr_tgt_true(rs_tgt_true), .wr_tgt_false(rs_tgt_false)
  );

  msbp_hist #(.HW(HW)) u_hist (
    .clk(clk), .rst(rst),
    .shift_en(lk_valid && hit_l), .shift_n(n_l), .shift_bits(sel_l),
    .fix_en(rs_ok && miss_r), .fix_snap(rs_hist), .fix_n(n_r), .fix_bits(sel_r),
    .ghr(ghr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_strobe <= 1'b0;
      pred_valid  <= 1'b0;
      pred_sel    <= '0;
      pred_tgt    <= '0;
      pred_hist   <= '0;
      pred_n      <= 2'd1;
    end else begin
      pred_strobe <= lk_valid;
      pred_valid  <= lk_valid && hit_l;
      if (lk_valid) begin
        pred_sel  <= hit_l ? sel_l : 3'd0;
        pred_tgt  <= hit_l ? btb_tgts[sel_l] : lk_addr + AW'(1);
        pred_hist <= ghr;
        pred_n    <= n_l;
      end
    end
  end

  a_r12_strobe: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_strobe);

  a_r4_fault_mask: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> ((pred_n == 2'd3) || !pred_sel[2]) && ((pred_n != 2'd1) || !pred_sel[1]));

endmodule

// File: tb/sim_msbp_top.sv
module sim_msbp_top;
  localparam int AW = 12, HW = 6, BI = 3;
  localparam int PD = 1 << HW, NE = 1 << BI;

  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, rs_valid = 0, rs_was_pred = 0;
  logic [AW-1:0] lk_addr = '0, rs_addr = '0, rs_tgt = '0, rs_tgt_true = '0, rs_tgt_false = '0;
  logic [HW-1:0] rs_hist = '0;
  logic [2:0] rs_pred_sel = '0, rs_sel = '0;
  logic [1:0] rs_nlog = 2'd1;
  logic pred_strobe, pred_valid;
  logic [2:0] pred_sel;
  logic [AW-1:0] pred_tgt;
  logic [HW-1:0] pred_hist;

  always #10 clk = ~clk;

  msbp_top #(.AW(AW), .HW(HW), .BI(BI)) u0 (
    .clk, .rst, .lk_valid, .lk_addr, .rs_valid, .rs_addr, .rs_hist, .rs_was_pred,
    .rs_pred_sel, .rs_sel, .rs_nlog, .rs_tgt, .rs_tgt_true, .rs_tgt_false,
    .pred_strobe, .pred_valid, .pred_sel, .pred_tgt, .pred_hist
  );

  int checks = 0, errors = 0;
  bit m_busy = 1;
  int unsigned   mc  [PD][3];
  bit            mev [NE];
  logic [AW-BI-1:0] mtag [NE];
  logic [1:0]    mn  [NE];
  logic [7:0]    msv [NE];
  logic [AW-1:0] mtg [NE][8];
  logic [HW-1:0] mghr = '0;

  function automatic logic [1:0] clampn(logic [1:0] n);
    return (n == 0) ? 2'd1 : n;
  endfunction
  function automatic logic [2:0] masks(logic [2:0] s, logic [1:0] n);
    return s & ((n == 3) ? 3'b111 : (n == 2) ? 3'b011 : 3'b001);
  endfunction
  function automatic logic [HW-1:0] hshift(logic [HW-1:0] h, logic [1:0] n, logic [2:0] b);
    return HW'((h << n) | (b & ((3'd1 << n) - 3'd1)));
  endfunction
  function automatic int unsigned cstep(int unsigned c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic fail(input string tag, input string act, input string exp);
    errors++;
    $display("FAIL %s actual=%s expected=%s", tag, act, exp);
  endtask

  task automatic set_rs(input logic [AW-1:0] a, input logic [HW-1:0] h, input bit w,
                        input logic [2:0] ps, input logic [2:0] s, input logic [AW-1:0] t,
                        input logic [1:0] n, input logic [AW-1:0] tt, input logic [AW-1:0] tf);
    rs_valid = 1; rs_addr = a; rs_hist = h; rs_was_pred = w; rs_pred_sel = ps;
    rs_sel = s; rs_tgt = t; rs_nlog = n; rs_tgt_true = tt; rs_tgt_false = tf;
  endtask

  // model of resolution effects; returns repair request
  task automatic apply_rs(output bit fix, output logic [HW-1:0] gn);
    logic [1:0] n; logic [2:0] s; bit mis, hb; int p, b;
    fix = 0; gn = '0;
    if (m_busy) return;
    n = clampn(rs_nlog); s = masks(rs_sel, n);
    mis = !rs_was_pred || rs_pred_sel != s;
    p = int'(rs_hist ^ rs_addr[HW-1:0]);
    mc[p][0] = cstep(mc[p][0], s[0]);
    if (n >= 2) mc[p][1] = cstep(mc[p][1], s[1]);
    if (n == 3) mc[p][2] = cstep(mc[p][2], s[2]);
    b = int'(rs_addr[BI-1:0]);
    hb = mev[b] && mtag[b] == rs_addr[AW-1:BI];
    if (!hb) begin
      mev[b] = 1; mtag[b] = rs_addr[AW-1:BI]; mn[b] = n;
      msv[b] = 8'b11 | (8'b1 << s);
      mtg[b][0] = rs_tgt_false; mtg[b][1] = rs_tgt_true;
      if (s > 1) mtg[b][s] = rs_tgt;
    end else if (mis) begin
      msv[b][s] = 1; mtg[b][s] = rs_tgt;
    end
    if (mis) begin fix = 1; gn = hshift(rs_hist, n, s); end
  endtask

  task automatic step(input bit lv, input logic [AW-1:0] la, input string tag);
    bit hv, fix; logic [2:0] s; logic [AW-1:0] t; logic [1:0] n; logic [HW-1:0] eh, gn; int p, b;
    lk_valid = lv; lk_addr = la;
    eh = mghr; b = int'(la[BI-1:0]);
    n = clampn(mn[b]);
    p = int'(mghr ^ la[HW-1:0]);
    s = masks({mc[p][2] >= 2, mc[p][1] >= 2, mc[p][0] >= 2}, n);
    hv = !m_busy && mev[b] && mtag[b] == la[AW-1:BI] && msv[b][s];
    t = hv ? mtg[b][s] : la + AW'(1);
    if (!hv) s = 0;
    fix = 0; gn = '0;
    if (rs_valid) apply_rs(fix, gn);
    if (fix) mghr = gn;
    else if (lv && hv) mghr = hshift(mghr, n, s);
    @(posedge clk); @(negedge clk);
    checks++;
    if (lv) begin
      if (!(pred_strobe === 1'b1 && pred_valid === hv && pred_sel === s &&
            pred_tgt === t && pred_hist === eh))
        fail(tag, $sformatf("s%0b v%0b sel%0d t%h h%h", pred_strobe, pred_valid, pred_sel, pred_tgt, pred_hist),
                  $sformatf("s1 v%0b sel%0d t%h h%h", hv, s, t, eh));
    end else if (pred_strobe !== 1'b0 || pred_valid !== 1'b0) begin
      fail({tag, " R12 idle"}, $sformatf("s%0b v%0b", pred_strobe, pred_valid), "s0 v0");
    end
    lk_valid = 0; rs_valid = 0;
  endtask

  logic [AW-1:0] pool [10];

  initial begin
    logic [AW-1:0] a, bb;
    logic [2:0] sr;
    logic [1:0] nr;
    for (int i = 0; i < PD; i++) for (int k = 0; k < 3; k++) mc[i][k] = 1;
    for (int e = 0; e < NE; e++) begin mev[e] = 0; mn[e] = 1; msv[e] = 0; mtag[e] = '0; end
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    checks++;
    if (pred_strobe !== 0 || pred_valid !== 0 || pred_hist !== 0)
      fail("R1 in reset", $sformatf("s%0b v%0b h%h", pred_strobe, pred_valid, pred_hist), "s0 v0 h0");
    rst = 0;
    @(negedge clk);
    checks++;
    if (pred_strobe !== 0 || pred_valid !== 0 || pred_hist !== 0)
      fail("R1 after reset", $sformatf("s%0b v%0b h%h", pred_strobe, pred_valid, pred_hist), "s0 v0 h0");

    // R13: resolution during the init sweep is dropped, lookups report no hit
    set_rs(12'h0F1, '0, 0, 0, 0, 12'h111, 2'd1, 12'h222, 12'h333);
    step(0, '0, "R13 init resolve");
    step(1, 12'h0F1, "R13 lookup during init");
    repeat (PD) step(0, '0, "R12 idle during init");
    m_busy = 0;
    step(1, 12'h0F1, "R13 dropped resolution leaves no entry");

    // R2 miss and unchanged history
    step(1, 12'h3C0, "R2 miss fall-through");
    step(1, 12'h3C0, "R2 history unchanged after miss");

    // R3 R5 allocation, weakly-not-taken start
    set_rs(12'h051, mghr, 0, 0, 0, 12'h400, 2'd1, 12'h500, 12'h400);
    step(0, '0, "R3 allocate");
    step(1, 12'h051, "R3 R5 fresh block predicts slot 0");

    // R6 training and saturation (matched outcomes keep history)
    set_rs(12'h051, mghr, 1, 1, 1, 12'h500, 2'd1, 12'h500, 12'h400); step(0, '0, "R6 train");
    set_rs(12'h051, mghr, 1, 1, 1, 12'h500, 2'd1, 12'h500, 12'h400); step(0, '0, "R6 train");
    set_rs(12'h051, mghr, 1, 1, 1, 12'h500, 2'd1, 12'h500, 12'h400); step(0, '0, "R6 saturate");
    set_rs(12'h051, mghr, 1, 1, 0, 12'h400, 2'd1, 12'h500, 12'h400); step(0, '0, "R6 one down");
    step(1, 12'h051, "R6 saturated counter still taken");

    // R7 R10 three-count block: allocate with fault outcome, empty slot miss, fill
    set_rs(12'h0A6, mghr, 0, 0, 7, 12'h777, 2'd3, 12'h701, 12'h700);
    step(0, '0, "R3 allocate with fault slot");
    step(1, 12'h0A6, "R7 three-bit shift lookup");
    step(1, 12'h3C0, "R7 history after three-bit shift");
    set_rs(12'h0A6, mghr, 1, 5, 5, 12'h755, 2'd3, 12'h701, 12'h700); step(0, '0, "R8 train");
    set_rs(12'h0A6, mghr, 1, 5, 5, 12'h755, 2'd3, 12'h701, 12'h700); step(0, '0, "R8 train");
    step(1, 12'h0A6, "R10 empty slot reported as miss");
    set_rs(12'h0A6, mghr, 1, 0, 5, 12'h755, 2'd3, 12'h701, 12'h700); step(0, '0, "R10 fill");
    set_rs(12'h0A6, mghr, 1, 5, 5, 12'h755, 2'd3, 12'h701, 12'h700); step(0, '0, "R8 train");
    set_rs(12'h0A6, mghr, 1, 5, 5, 12'h755, 2'd3, 12'h701, 12'h700); step(0, '0, "R8 train");
    step(1, 12'h0A6, "R10 filled slot predicted");

    // R9 repair overrides same-cycle shift
    set_rs(12'h051, 6'h15, 0, 0, 1, 12'h500, 2'd1, 12'h500, 12'h400);
    step(1, 12'h0A6, "R9 lookup alongside repair");
    step(1, 12'h3C0, "R9 repaired history");

    // R11 same-cycle allocate and lookup
    set_rs(12'h2E4, mghr, 0, 0, 0, 12'h600, 2'd2, 12'h601, 12'h600);
    step(1, 12'h2E4, "R11 lookup sees pre-write table");
    step(1, 12'h2E4, "R11 entry visible next cycle");

    // constrained random mix
    for (int i = 0; i < 10; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 3000; i++) begin
      a = pool[$urandom_range(0, 9)];
      if ($urandom_range(0, 2) != 0) begin
        bb = pool[$urandom_range(0, 9)];
        sr = 3'($urandom);
        nr = bb[1:0];
        set_rs(bb, ($urandom_range(0, 1) != 0) ? mghr : HW'($urandom), 1'($urandom),
               ($urandom_range(0, 1) != 0) ? masks(sr, clampn(nr)) : 3'($urandom),
               sr, AW'($urandom), nr, bb ^ 12'h5A5, bb + AW'(1));
      end
      step($urandom_range(0, 3) != 0, a, "R4 R6 R7 R8 R9 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule